// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block holds the reservation state of one processor for atomic read-modify-write sequences that are built from a load-reserve and a later store-conditional. The processor side presents one request per cycle. Each request carries an operation code and an address. A load-reserve records a reservation on the cache block that holds the address. A store-conditional is then judged against that reservation, and the block returns a pass or fail status one cycle later. The memory read and write themselves happen elsewhere. This block only decides whether the conditional write may go ahead.

On the bus side the block watches store traffic from other agents. A store that lands anywhere inside the reserved block removes the reservation. Several processors may therefore hold reservations on the same block at once, and the first one to complete its conditional store wins. When a conditional store passes, the block raises a one-cycle cancel indication that carries the block-aligned address. The bus logic turns this into an ordinary store that the other snoopers see. Reservations are tracked per block: the low offset bits of every address are ignored in all comparisons.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, no reservation is held (`resv_valid` = 0), and `sc_done`, `sc_ok` and `cancel_valid` are all 0.
- R2: A request with `req_op` = 2'b01 (load-reserve) sets `resv_valid` at the next edge and loads `resv_addr` with `req_addr` with its low `OFS_W` bits zeroed. This overwrites any earlier reservation. Op codes 2'b00 and 2'b11 change nothing.
- R3: A request with `req_op` = 2'b10 (store-conditional) passes when a reservation is held and `req_addr` lies in the reserved block, at any offset. On the next cycle `sc_done` = 1 and `sc_ok` = 1.
- R4: A store-conditional fails when no reservation is held or its block differs from the reserved one. On the next cycle `sc_done` = 1 and `sc_ok` = 0.
- R5: Every store-conditional clears the reservation, whether it passes or fails.
- R6: A passing store-conditional raises `cancel_valid` for exactly one cycle, the same cycle as `sc_done`. `cancel_addr` carries the block-aligned address. A failing one leaves `cancel_valid` at 0.
- R7: A snooped store (`snoop_valid` = 1 and `snoop_store` = 1) to any offset of the reserved block clears the reservation. Snooped loads, and stores to other blocks, leave it unchanged.
- R8: If a snooped store hits the reserved block in the same cycle as a store-conditional to that block, the snoop is ordered first and the store-conditional fails.
- R9: If a load-reserve and a snooped store to the same block arrive in the same cycle, the snoop is ordered first and the new reservation stands.
- R10: `sc_ok` holds the result of the most recent store-conditional until the next one completes. `sc_done` pulses for one cycle per store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_op | input | 2 | 01 load-reserve, 10 store-conditional, others no-op |
| req_addr | input | ADDR_W | Request byte address |
| snoop_valid | input | 1 | Bus transaction from another agent seen this cycle |
| snoop_store | input | 1 | Snooped transaction is a store (0 means a load) |
| snoop_addr | input | ADDR_W | Snooped byte address |
| sc_done | output | 1 | One-cycle pulse: a store-conditional was judged |
| sc_ok | output | 1 | Result of the most recent store-conditional |
| cancel_valid | output | 1 | One-cycle pulse: reservations elsewhere on this block must drop |
| cancel_addr | output | ADDR_W | Block-aligned address of the cancel |
| resv_valid | output | 1 | Reservation flag |
| resv_addr | output | ADDR_W | Reserved block address, offset bits zero |

## Verification
The assertions assume at most one request per cycle, which the single-op port already enforces. They also assume the inputs are known whenever `rst_n` is high. The properties relate each request to its effect one cycle later, so they rely on the status and reservation registers being updated in the cycle after a request. The bench drives every input on the falling edge and returns each input to idle after a one-cycle request. As a result, a request is never seen on two consecutive edges unless a scenario means it to be.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    LRSC_NOP  = 2'b00,
    LRSC_LR   = 2'b01,
    LRSC_SC   = 2'b10,
    LRSC_RSVD = 2'b11
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_blk_match.sv
module lrsc_blk_match #(
  parameter int BLK_W = 28
) (
  input  logic             en,
  input  logic [BLK_W-1:0] blk_a,
  input  logic [BLK_W-1:0] blk_b,
  output logic             hit
);
  function automatic logic same_blk(input logic [BLK_W-1:0] a, input logic [BLK_W-1:0] b);
    return a == b;
  endfunction

  assign hit = en && same_blk(blk_a, blk_b);
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int BLK_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [BLK_W-1:0] set_blk,
  input  logic             clr,
  output logic             flag,
  output logic [BLK_W-1:0] blk
);
  // a new reservation has priority over any clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      blk  <= '0;
    end else if (set) begin
      flag <= 1'b1;
      blk  <= set_blk;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_sc_status.sv
module lrsc_sc_status #(
  parameter int BLK_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_req,
  input  logic             sc_pass,
  input  logic [BLK_W-1:0] sc_blk,
  output logic             done,
  output logic             ok,
  output logic             cancel,
  output logic [BLK_W-1:0] cancel_blk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      ok         <= 1'b0;
      cancel     <= 1'b0;
      cancel_blk <= '0;
    end else begin
      done   <= sc_req;
      cancel <= sc_pass;
      if (sc_req) ok <= sc_pass;
      if (sc_pass) cancel_blk <= sc_blk;
    end
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic              snoop_store,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              cancel_valid,
  output logic [ADDR_W-1:0] cancel_addr,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);
  localparam int BLK_W = ADDR_W - OFS_W;

  lrsc_op_e         op;
  logic             lr_req, sc_req;
  logic             snoop_hit, sc_match, sc_pass;
  logic [BLK_W-1:0] req_blk, snoop_blk, resv_blk, cancel_blk;

  assign op        = lrsc_op_e'(req_op);
  assign lr_req    = req_valid && (op == LRSC_LR);
  assign sc_req    = req_valid && (op == LRSC_SC);
  assign req_blk   = req_addr[ADDR_W-1:OFS_W];
  assign snoop_blk = snoop_addr[ADDR_W-1:OFS_W];

  lrsc_blk_match #(.BLK_W(BLK_W)) snoop_cmp_i (
    .en    (snoop_valid && snoop_store && resv_valid),
    .blk_a (snoop_blk),
    .blk_b (resv_blk),
    .hit   (snoop_hit)
  );

  lrsc_blk_match #(.BLK_W(BLK_W)) sc_cmp_i (
    .en    (resv_valid),
    .blk_a (req_blk),
    .blk_b (resv_blk),
    .hit   (sc_match)
  );

  // a snooped store in the same cycle is ordered ahead of the conditional store
  assign sc_pass = sc_req && sc_match && !snoop_hit;

  lrsc_resv_reg #(.BLK_W(BLK_W)) resv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (lr_req),
    .set_blk (req_blk),
    .clr     (sc_req || snoop_hit),
    .flag    (resv_valid),
    .blk     (resv_blk)
  );

  lrsc_sc_status #(.BLK_W(BLK_W)) stat_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_req     (sc_req),
    .sc_pass    (sc_pass),
    .sc_blk     (req_blk),
    .done       (sc_done),
    .ok         (sc_ok),
    .cancel     (cancel_valid),
    .cancel_blk (cancel_blk)
  );

  assign resv_addr   = {resv_blk, {OFS_W{1'b0}}};
  assign cancel_addr = {cancel_blk, {OFS_W{1'b0}}};
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lr_req,
  input logic              sc_req,
  input logic              snoop_hit,
  input logic [ADDR_W-1:0] req_addr,
  input logic              sc_done,
  input logic              sc_ok,
  input logic              cancel_valid,
  input logic              resv_valid,
  input logic [ADDR_W-1:0] resv_addr
);
  // R2
  lr_sets_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_req |=> resv_valid && (resv_addr[ADDR_W-1:OFS_W] == $past(req_addr[ADDR_W-1:OFS_W])));
  // R3
  sc_pass_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && resv_valid && !snoop_hit &&
     (req_addr[ADDR_W-1:OFS_W] == resv_addr[ADDR_W-1:OFS_W])) |=> sc_done && sc_ok);
  // R4
  sc_no_resv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !resv_valid) |=> sc_done && !sc_ok);
  // R5
  sc_clears_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !resv_valid);
  // R6
  cancel_only_on_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_valid |-> sc_done && sc_ok);
  // R7
  snoop_clears_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !lr_req) |=> !resv_valid);
  // R8
  snoop_beats_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && snoop_hit) |=> !sc_ok);
  // R10
  status_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_done |-> $stable(sc_ok));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .lr_req       (lr_req),
  .sc_req       (sc_req),
  .snoop_hit    (snoop_hit),
  .req_addr     (req_addr),
  .sc_done      (sc_done),
  .sc_ok        (sc_ok),
  .cancel_valid (cancel_valid),
  .resv_valid   (resv_valid),
  .resv_addr    (resv_addr)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic          snoop_valid = 1'b0;
  logic          snoop_store = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          sc_done, sc_ok, cancel_valid, resv_valid;
  logic [AW-1:0] cancel_addr, resv_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor #(.ADDR_W(AW), .OFS_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .snoop_valid(snoop_valid), .snoop_store(snoop_store), .snoop_addr(snoop_addr),
    .sc_done(sc_done), .sc_ok(sc_ok), .cancel_valid(cancel_valid), .cancel_addr(cancel_addr),
    .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~32'hF;
  endfunction

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; applies one cycle of inputs, returns at the next falling edge with inputs idle
  task automatic cyc(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic sv, input logic ss, input logic [AW-1:0] sa);
    req_valid = v; req_op = op; req_addr = a;
    snoop_valid = sv; snoop_store = ss; snoop_addr = sa;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00; req_addr = '0;
    snoop_valid = 1'b0; snoop_store = 1'b0; snoop_addr = '0;
  endtask

  task automatic lr(input logic [AW-1:0] a);  cyc(1, 2'b01, a, 0, 0, '0); endtask
  task automatic sc(input logic [AW-1:0] a);  cyc(1, 2'b10, a, 0, 0, '0); endtask
  task automatic idle();                      cyc(0, 2'b00, '0, 0, 0, '0); endtask

  task automatic t_reset();
    chk("R1", "resv_valid", resv_valid, 0);
    chk("R1", "sc_done", sc_done, 0);
    chk("R1", "sc_ok", sc_ok, 0);
    chk("R1", "cancel_valid", cancel_valid, 0);
  endtask

  task automatic t_pass();
    lr(32'h1234_5678);
    chk("R2", "resv_valid", resv_valid, 1);
    chk("R2", "resv_addr", resv_addr, align(32'h1234_5678));
    sc(32'h1234_567C);
    chk("R3", "sc_done", sc_done, 1);
    chk("R3", "sc_ok", sc_ok, 1);
    chk("R6", "cancel_valid", cancel_valid, 1);
    chk("R6", "cancel_addr", cancel_addr, 32'h1234_5670);
    chk("R5", "resv_valid after pass", resv_valid, 0);
    idle();
    chk("R6", "cancel one cycle", cancel_valid, 0);
    chk("R10", "sc_done one cycle", sc_done, 0);
    chk("R10", "sc_ok held", sc_ok, 1);
  endtask

  task automatic t_fail();
    sc(32'h0000_0100);
    chk("R4", "no-resv sc_done", sc_done, 1);
    chk("R4", "no-resv sc_ok", sc_ok, 0);
    chk("R6", "no cancel on fail", cancel_valid, 0);
    lr(32'h0000_2000);
    sc(32'h0000_2010);
    chk("R4", "other block sc_ok", sc_ok, 0);
    chk("R5", "resv cleared on fail", resv_valid, 0);
    idle();
    chk("R10", "fail status held", sc_ok, 0);
  endtask

  task automatic t_overwrite();
    lr(32'h0000_3000);
    lr(32'h0000_4004);
    chk("R2", "overwrite addr", resv_addr, 32'h0000_4000);
    cyc(1, 2'b11, 32'h0000_5000, 0, 0, '0);
    chk("R2", "op 11 resv kept", resv_valid, 1);
    chk("R2", "op 11 addr kept", resv_addr, 32'h0000_4000);
    chk("R2", "op 11 no sc_done", sc_done, 0);
    cyc(1, 2'b00, 32'h0000_5000, 0, 0, '0);
    chk("R2", "op 00 addr kept", resv_addr, 32'h0000_4000);
    sc(32'h0000_3000);
    chk("R2", "old resv gone", sc_ok, 0);
  endtask

  task automatic t_snoop();
    lr(32'h0000_6000);
    cyc(0, 2'b00, '0, 1, 0, 32'h0000_6004);
    chk("R7", "snoop load ignored", resv_valid, 1);
    cyc(0, 2'b00, '0, 1, 1, 32'h0000_7000);
    chk("R7", "other-block store ignored", resv_valid, 1);
    cyc(0, 2'b00, '0, 1, 1, 32'h0000_600C);
    chk("R7", "same-block store clears", resv_valid, 0);
    sc(32'h0000_6000);
    chk("R7", "sc after snoop fails", sc_ok, 0);
  endtask

  task automatic t_collide();
    lr(32'h0000_8000);
    cyc(1, 2'b10, 32'h0000_8000, 1, 1, 32'h0000_8008);
    chk("R8", "collision sc_done", sc_done, 1);
    chk("R8", "collision sc_ok", sc_ok, 0);
    chk("R8", "collision no cancel", cancel_valid, 0);
    lr(32'h0000_9000);
    lr(32'h0000_A000);
    cyc(1, 2'b01, 32'h0000_A000, 1, 1, 32'h0000_A004);
    chk("R9", "lr beats snoop flag", resv_valid, 1);
    chk("R9", "lr beats snoop addr", resv_addr, 32'h0000_A000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_fail();
    t_overwrite();
    t_snoop();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule